// File: doc/BRIEF.md
# Cooking Timer Controller

This block runs the timing side of a cooking appliance. A five-state controller handles a display self-test, the loading of a preset cooking time, the countdown itself, and a completion message. A four-digit BCD countdown holds the remaining time as minutes tens, minutes units, seconds tens and seconds units. It loses one second on every one-second tick while the heater is on.

The host drives level requests for display test, time setting and start, plus a one-cycle `tick_1s` pulse once per second. The preset time comes in as four BCD digits. The block returns the cook enable, three display strobes, the live digits and a registered zero flag per digit. Seven-segment decoding and display multiplexing belong to other blocks.

Top module: `cook_timer_top`

## Requirements
- R1: An active-high asynchronous reset leads at once to the idle state. In that state the cook enable and all three strobes are low, every digit reads 0 and all zero flags read 1.
- R2: From idle, a test request wins over a set request, and a set request wins over start. Start is ignored and the block stays idle while all four digits are 0.
- R3: In the lamp-test state only `lamp_strobe` is high. The block stays there while `test_req` is held and returns to idle on the first edge where it is low. At most one of cook enable and the three strobes is high in any cycle.
- R4: In the set-clock state only `load_strobe` is high. On every clock edge in this state the digits take the preset. The state holds while `set_req` is high and returns to idle when it drops.
- R5: The preset and digit fields are packed as follows: [15:12] minutes tens, [11:8] minutes units, [7:4] seconds tens, [3:0] seconds units. Any preset digit above its limit loads as the limit. The limit is 5 for seconds tens and 9 for the others.
- R6: In the timer state `cook_en` is high while any digit is nonzero. Each tick reduces the time by exactly one second. Without a tick the digits hold.
- R7: Seconds units and both minutes digits count down to 0 and then wrap to 9. Seconds tens wraps from 0 to 5. A digit steps only on a tick when every lower digit is 0.
- R8: When the timer state reaches 0000, `cook_en` is low in that same cycle. The next edge enters the done-message state, which raises `done_strobe` and holds the digits at 0000 with no wrap.
- R9: The done-message state returns to idle on a set or test request and ignores start. The timer state ignores set, test and start.
- R10: Each bit of `zero_flags` (bit 0 = seconds units … bit 3 = minutes tens) is high exactly when that digit was 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| tick_1s | input | 1 | One-cycle pulse per elapsed second |
| set_req | input | 1 | Request to load the preset time |
| start_req | input | 1 | Request to begin cooking |
| test_req | input | 1 | Request for display lamp test |
| preset_bcd | input | 16 | Preset time, four BCD digits |
| cook_en | output | 1 | Heater enable |
| lamp_strobe | output | 1 | All-segments-on display strobe |
| load_strobe | output | 1 | Time-loading display strobe |
| done_strobe | output | 1 | Completion message strobe |
| digits_bcd | output | 16 | Remaining time, four BCD digits |
| zero_flags | output | 4 | Registered per-digit zero flags |

## Verification
A wrong controller state shows on the strobes and cook enable in the same cycle, because these outputs decode the state directly. A bad borrow or wrap becomes visible on `digits_bcd` on the first tick edge that crosses a digit boundary. A missed terminal count shows one cycle later, as `done_strobe` failing to rise or as the digits wrapping past 0000. The bench keeps its own model of the remaining time in whole seconds and converts it to BCD. Every cycle it compares all outputs against that model, so any divergence is caught in the cycle it first appears.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LAMP = 3'd1,
    ST_SET  = 3'd2,
    ST_RUN  = 3'd3,
    ST_DONE = 3'd4
  } ct_state_e;

  // Upper limit of digit position i (0 = seconds units).
  function automatic logic [DIGIT_W-1:0] digit_limit(input int i);
    return ((i % 4) == 1) ? DIGIT_W'(5) : DIGIT_W'(9);
  endfunction

  // Saturate a loaded digit to its limit.
  function automatic logic [DIGIT_W-1:0] sat_digit(input logic [DIGIT_W-1:0] v,
                                                   input logic [DIGIT_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // One step down with wrap to the limit.
  function automatic logic [DIGIT_W-1:0] step_down(input logic [DIGIT_W-1:0] v,
                                                   input logic [DIGIT_W-1:0] lim);
    return (v == '0) ? lim : v - DIGIT_W'(1);
  endfunction
endpackage

// File: rtl/ct_digit.sv
module ct_digit
  import ct_pkg::*;
#(
  parameter logic [DIGIT_W-1:0] LIMIT = 4'd9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               dec,
  input  logic [DIGIT_W-1:0] load_val,
  output logic [DIGIT_W-1:0] value,
  output logic               zero_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      value  <= '0;
      zero_q <= 1'b1;
    end else begin
      zero_q <= (value == '0);
      if (load)
        value <= sat_digit(load_val, LIMIT);
      else if (dec)
        value <= step_down(value, LIMIT);
    end
  end
endmodule

// File: rtl/ct_chain.sv
module ct_chain
  import ct_pkg::*;
#(
  parameter int N_DIGITS = 4,
  localparam int TW = N_DIGITS * DIGIT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                dec,
  input  logic [TW-1:0]       preset,
  output logic [TW-1:0]       digits,
  output logic [N_DIGITS-1:0] zflags,
  output logic                all_zero
);
  logic [N_DIGITS-1:0] step_en;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_dig
    localparam logic [DIGIT_W-1:0] LIM = digit_limit(i);
    if (i == 0) begin : g_first
      assign step_en[i] = dec;
    end else begin : g_rest
      assign step_en[i] = step_en[i-1] & (digits[(i-1)*DIGIT_W +: DIGIT_W] == '0);
    end
    ct_digit #(.LIMIT(LIM)) u_digit (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .dec      (step_en[i]),
      .load_val (preset[i*DIGIT_W +: DIGIT_W]),
      .value    (digits[i*DIGIT_W +: DIGIT_W]),
      .zero_q   (zflags[i])
    );
  end

  assign all_zero = (digits == '0);
endmodule

// File: rtl/ct_ctrl.sv
module ct_ctrl
  import ct_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_req,
  input  logic      start_req,
  input  logic      test_req,
  input  logic      tick_1s,
  input  logic      all_zero,
  output ct_state_e state,
  output logic      load_now,
  output logic      dec_now,
  output logic      cook_en,
  output logic      lamp_strobe,
  output logic      load_strobe,
  output logic      done_strobe
);
  ct_state_e nxt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (test_req)                     nxt = ST_LAMP;
        else if (set_req)                 nxt = ST_SET;
        else if (start_req && !all_zero)  nxt = ST_RUN;
      end
      ST_LAMP: if (!test_req)             nxt = ST_IDLE;
      ST_SET:  if (!set_req)              nxt = ST_IDLE;
      ST_RUN:  if (all_zero)              nxt = ST_DONE;
      ST_DONE: if (set_req || test_req)   nxt = ST_IDLE;
      default:                            nxt = ST_IDLE;
    endcase
  end

  assign lamp_strobe = (state == ST_LAMP);
  assign load_strobe = (state == ST_SET);
  assign done_strobe = (state == ST_DONE);
  assign cook_en     = (state == ST_RUN) && !all_zero;
  assign load_now    = load_strobe;
  assign dec_now     = cook_en && tick_1s;
endmodule

// File: rtl/cook_timer_top.sv
module cook_timer_top
  import ct_pkg::*;
#(
  parameter int N_DIGITS = 4,
  localparam int TW = N_DIGITS * DIGIT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_1s,
  input  logic                set_req,
  input  logic                start_req,
  input  logic                test_req,
  input  logic [TW-1:0]       preset_bcd,
  output logic                cook_en,
  output logic                lamp_strobe,
  output logic                load_strobe,
  output logic                done_strobe,
  output logic [TW-1:0]       digits_bcd,
  output logic [N_DIGITS-1:0] zero_flags
);
  ct_state_e state_q;
  logic      load_now;
  logic      dec_now;
  logic      all_zero;

  ct_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .set_req     (set_req),
    .start_req   (start_req),
    .test_req    (test_req),
    .tick_1s     (tick_1s),
    .all_zero    (all_zero),
    .state       (state_q),
    .load_now    (load_now),
    .dec_now     (dec_now),
    .cook_en     (cook_en),
    .lamp_strobe (lamp_strobe),
    .load_strobe (load_strobe),
    .done_strobe (done_strobe)
  );

  ct_chain #(.N_DIGITS(N_DIGITS)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .load     (load_now),
    .dec      (dec_now),
    .preset   (preset_bcd),
    .digits   (digits_bcd),
    .zflags   (zero_flags),
    .all_zero (all_zero)
  );
endmodule

// File: rtl/cook_timer_chk.sv
module cook_timer_chk
  import ct_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      tick_1s,
  input logic      set_req,
  input logic      start_req,
  input logic      test_req,
  input logic [15:0] preset_bcd,
  input logic      cook_en,
  input logic      lamp_strobe,
  input logic      load_strobe,
  input logic      done_strobe,
  input logic [15:0] digits_bcd,
  input logic [3:0]  zero_flags,
  input ct_state_e state_q
);
  p_one_output_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cook_en, lamp_strobe, load_strobe, done_strobe}));

  p_cook_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    cook_en |-> (digits_bcd != 16'h0000));

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !tick_1s) |=> $stable(digits_bcd));

  p_sec_tens_range_r7: assert property (@(posedge clk) disable iff (rst)
    digits_bcd[7:4] <= 4'd5);

  p_zero_to_done_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && digits_bcd == 16'h0000) |=> done_strobe);

  p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (done_strobe && !set_req && !test_req) |=> (done_strobe && digits_bcd == 16'h0000));

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && digits_bcd == 16'h0000 && !test_req && !set_req) |=> !cook_en);

  p_zero_flag_su_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (zero_flags[0] == ($past(digits_bcd[3:0]) == 4'd0)));

  p_zero_flag_mt_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (zero_flags[3] == ($past(digits_bcd[15:12]) == 4'd0)));
endmodule

bind cook_timer_top cook_timer_chk u_chk (.*);

// File: tb/tb_cook_timer_top.sv
`timescale 1ns/1ps
module tb_cook_timer_top;
  localparam int S_IDLE = 0, S_LAMP = 1, S_SET = 2, S_RUN = 3, S_DONE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1s = 0, set_req = 0, start_req = 0, test_req = 0;
  logic [15:0] preset_bcd = '0;
  logic cook_en, lamp_strobe, load_strobe, done_strobe;
  logic [15:0] digits_bcd;
  logic [3:0]  zero_flags;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_state = S_IDLE, m_secs = 0;
  logic [3:0] m_zf = 4'hF;

  always #4 clk = ~clk;

  cook_timer_top dut (.*);

  function automatic logic [15:0] to_bcd(input int s);
    return {4'(s / 600), 4'((s / 60) % 10), 4'((s % 60) / 10), 4'(s % 10)};
  endfunction

  function automatic int lim(input int d, input int cap);
    return (d > cap) ? cap : d;
  endfunction

  function automatic int preset_secs(input logic [15:0] p);
    return lim(int'(p[15:12]), 9) * 600 + lim(int'(p[11:8]), 9) * 60 +
           lim(int'(p[7:4]), 5) * 10 + lim(int'(p[3:0]), 9);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_model();
    logic [15:0] d;
    d = to_bcd(m_secs);
    chk("R6 cook_en",     16'(cook_en),     16'(m_state == S_RUN && m_secs != 0));
    chk("R3 lamp_strobe", 16'(lamp_strobe), 16'(m_state == S_LAMP));
    chk("R4 load_strobe", 16'(load_strobe), 16'(m_state == S_SET));
    chk("R8 done_strobe", 16'(done_strobe), 16'(m_state == S_DONE));
    chk("R7 digits",      digits_bcd,       d);
    chk("R10 zero_flags", 16'(zero_flags),  16'(m_zf));
  endtask

  task automatic step(input logic tk, input logic st, input logic sr, input logic ts,
                      input logic [15:0] p);
    int ns, nsecs;
    logic [15:0] d;
    tick_1s = tk; set_req = st; start_req = sr; test_req = ts; preset_bcd = p;
    ns = m_state; nsecs = m_secs;
    case (m_state)
      S_IDLE: if (ts) ns = S_LAMP; else if (st) ns = S_SET;
              else if (sr && m_secs != 0) ns = S_RUN;
      S_LAMP: if (!ts) ns = S_IDLE;
      S_SET:  if (!st) ns = S_IDLE;
      S_RUN:  if (m_secs == 0) ns = S_DONE;
      default: if (st || ts) ns = S_IDLE;
    endcase
    if (m_state == S_SET) nsecs = preset_secs(p);
    else if (m_state == S_RUN && tk && m_secs != 0) nsecs = m_secs - 1;
    d = to_bcd(m_secs);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    m_zf = {d[15:12] == 0, d[11:8] == 0, d[7:4] == 0, d[3:0] == 0};
    m_state = ns; m_secs = nsecs;
    check_model();
  endtask

  task automatic idle1(); step(0, 0, 0, 0, preset_bcd); endtask

  task automatic load_time(input logic [15:0] p);
    step(0, 1, 0, 0, p);
    step(0, 0, 0, 0, p);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 cook", 16'(cook_en), 16'h0);
    chk("R1 strobes", 16'({lamp_strobe, load_strobe, done_strobe}), 16'h0);
    chk("R1 digits", digits_bcd, 16'h0000);
    chk("R1 flags", 16'(zero_flags), 16'hF);
    rst = 1'b0;
    idle1();

    // R2 start ignored with zero time
    step(0, 0, 1, 0, 16'h0000);
    chk("R2 start ignored", 16'(cook_en), 16'h0);
    // R2 priority: test wins
    step(0, 1, 1, 1, 16'h0123);
    chk("R2 test priority", 16'(lamp_strobe), 16'h1);
    step(0, 0, 0, 1, 16'h0123);
    chk("R3 lamp held", 16'(lamp_strobe), 16'h1);
    idle1();
    chk("R3 lamp released", 16'(lamp_strobe), 16'h0);

    // R5 clamp of out-of-range digits
    load_time(16'hFA7C);
    chk("R5 clamp load", digits_bcd, 16'h9959);
    // R4 set held reloads with new preset
    step(0, 1, 0, 0, 16'h0042);
    step(0, 1, 0, 0, 16'h0042);
    chk("R4 load while held", digits_bcd, 16'h0042);
    step(0, 0, 0, 0, 16'h0105);

    // 01:05 countdown
    chk("R4 final load", digits_bcd, 16'h0105);
    step(0, 0, 1, 0, 16'h0105);
    chk("R6 cook on", 16'(cook_en), 16'h1);
    for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 16'h0105);
    chk("R6 after 64 ticks", digits_bcd, 16'h0001);
    step(0, 1, 1, 1, 16'h0105);
    chk("R9 run ignores requests", 16'(cook_en), 16'h1);
    step(1, 0, 0, 0, 16'h0105);
    chk("R8 zero digits", digits_bcd, 16'h0000);
    chk("R8 cook drops", 16'(cook_en), 16'h0);
    step(1, 0, 0, 0, 16'h0105);
    chk("R8 done strobe", 16'(done_strobe), 16'h1);
    chk("R8 no wrap", digits_bcd, 16'h0000);
    step(1, 0, 1, 0, 16'h0105);
    chk("R9 start ignored in done", 16'(done_strobe), 16'h1);
    step(0, 1, 0, 0, 16'h0105);
    chk("R9 done exits", 16'(done_strobe), 16'h0);

    // R7 multi-level borrow
    load_time(16'h1000);
    step(0, 0, 1, 0, 16'h1000);
    step(1, 0, 0, 0, 16'h1000);
    chk("R7 borrow 10:00", digits_bcd, 16'h0959);
    chk("R10 flags after borrow", 16'(zero_flags), 16'h7);
    step(0, 0, 0, 0, 16'h1000);
    chk("R6 hold without tick", digits_bcd, 16'h0959);

    // R1 asynchronous reset mid-run
    rst = 1'b1;
    #1;
    chk("R1 async digits", digits_bcd, 16'h0000);
    chk("R1 async cook", 16'(cook_en), 16'h0);
    @(negedge clk);
    rst = 1'b0;
    m_state = S_IDLE; m_secs = 0; m_zf = 4'hF;
    idle1();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [15:0] p;
      r = int'($urandom % 100);
      p = (r < 20) ? 16'($urandom) : {4'($urandom % 2), 4'($urandom % 10), 4'($urandom % 6), 4'($urandom % 10)};
      step(($urandom % 100) < 70, ($urandom % 100) < 4, ($urandom % 100) < 25,
           ($urandom % 100) < 3, p);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule